// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block sits in the fetch stage and chooses the next fetch address in the same cycle as the fetch address arrives. It holds a direct-mapped table of entries, each with a valid bit, a tag, a stored branch target and a 2-bit saturating direction counter. The low bits of the fetch address, above the byte offset, select an entry. When the stored tag matches the rest of the fetch address, the instruction is treated as a known branch. If its counter predicts taken, the stored target is steered to the next address. Otherwise the next address is the sequential one, four bytes on.

Resolved branches come back from later stages through an update stream. A taken branch that is not yet in the table claims its slot, replacing any other branch that shares the index. A branch that already has an entry trains its counter, and a taken one also refreshes its target. A flush input invalidates the whole table at once. The update stream obeys valid/ready. `upd_ready` is low exactly in a flush cycle, and an update offered then is not taken. The producer must keep the same update on the port until it sees valid and ready high together. An update is accepted on any cycle without a flush, so there is no other back-pressure.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid: every lookup misses and `upd_ready` is 1.
- R2: On a lookup miss, `pred_hit` and `pred_taken` are 0 and `next_pc` equals `fetch_pc + 4`.
- R3: An accepted taken update whose address misses allocates the entry. It stores the tag, the target and the counter value weakly taken (2'b10). A later lookup of that address hits, predicts taken and gives the stored target. `pred_taken` is never 1 without `pred_hit`.
- R4: An accepted not-taken update whose address misses leaves the table unchanged: a later lookup of that address still misses.
- R5: The counter encodes 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken and 2'b11 strongly taken; the prediction is taken when bit 1 is set. From strongly taken, one not-taken update still leaves the prediction taken, and a second one flips it.
- R6: The counter saturates at both ends. From 2'b00, further not-taken updates keep it at 2'b00, so a single taken update afterwards still predicts not taken.
- R7: A taken update to a hit entry increments the counter and replaces the stored target. A not-taken update to a hit entry decrements the counter and keeps the stored target.
- R8: Two addresses with the same index but different tags do not alias: a lookup of the other address misses. A taken update of it overwrites the entry with its own tag and target, and the counter becomes weakly taken. The previous owner then misses.
- R9: While `flush` is 1, `upd_ready` is 0 and an offered update is not taken. From the next cycle on, every lookup misses.
- R10: A lookup reflects the table as it was before any update accepted in the same cycle. The update becomes visible in the following cycle.
- R11: The entry index is `fetch_pc[IDX_W+1:2]` and the tag is `fetch_pc[PC_W-1:IDX_W+2]`. Entries at different indices are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate every entry |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address matches a valid entry |
| pred_taken | output | 1 | Hit and counter predicts taken |
| next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is offered |
| upd_ready | output | 1 | Update accepted this cycle (low during flush) |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | PC_W | Resolved target address |

## Verification
Lookup and update meet in one cycle when the fetch address and the update address fall on the same entry. The bench drives both together. It checks that the outputs in that cycle still show the old entry: a miss before a taken allocation, and the old counter value during training. It then looks the same address up on the next cycle and checks that the new state is there. Flush and update meet in a second case. An update offered in a flush cycle must see `upd_ready` low and must leave no entry behind, and this is judged by lookups after the flush.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } dir_ctr_e;

  localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/btb_dir_train.sv
module btb_dir_train
  import btb_pkg::*;
(
  input  logic     hit,
  input  logic     taken,
  input  dir_ctr_e cur_ctr,
  output dir_ctr_e new_ctr
);
  always_comb begin
    if (!hit) begin
      new_ctr = CTR_WT;
    end else if (taken) begin
      new_ctr = (cur_ctr == CTR_ST) ? CTR_ST : dir_ctr_e'(cur_ctr + 2'd1);
    end else begin
      new_ctr = (cur_ctr == CTR_SNT) ? CTR_SNT : dir_ctr_e'(cur_ctr - 2'd1);
    end
  end
endmodule

// File: rtl/btb_entry_store.sv
module btb_entry_store
  import btb_pkg::*;
#(
  parameter int TAG_W = 26,
  parameter int TGT_W = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_tgt_en,
  input  logic [TGT_W-1:0] wr_target,
  input  dir_ctr_e         wr_ctr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_target,
  output dir_ctr_e         rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_valid,
  output logic [TAG_W-1:0] up_tag,
  output dir_ctr_e         up_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic             v_q   [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TGT_W-1:0] tgt_q [DEPTH];
  dir_ctr_e         ctr_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[e]   <= 1'b0;
        tag_q[e] <= '0;
        tgt_q[e] <= '0;
        ctr_q[e] <= CTR_SNT;
      end else if (flush) begin
        v_q[e] <= 1'b0;
      end else if (sel) begin
        v_q[e]   <= 1'b1;
        tag_q[e] <= wr_tag;
        ctr_q[e] <= wr_ctr;
        if (wr_tgt_en) tgt_q[e] <= wr_target;
      end
    end
  end

  assign rd_valid  = v_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
  assign rd_ctr    = ctr_q[rd_idx];
  assign up_valid  = v_q[up_idx];
  assign up_tag    = tag_q[up_idx];
  assign up_ctr    = ctr_q[up_idx];
endmodule

// File: rtl/btb_fetch_select.sv
module btb_fetch_select
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 26
) (
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [TAG_W-1:0] pc_tag,
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PC_W-1:0]  ent_target,
  input  dir_ctr_e         ent_ctr,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  logic [PC_W-1:0] seq_pc;
  assign seq_pc  = fetch_pc + PC_W'(INSN_BYTES);
  assign hit     = ent_valid && (ent_tag == pc_tag);
  assign taken   = hit && ent_ctr[1];
  assign next_pc = taken ? ent_target : seq_pc;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int OFS_W = $clog2(INSN_BYTES);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             rd_valid, up_valid;
  logic [TAG_W-1:0] rd_tag, up_tag;
  logic [PC_W-1:0]  rd_target;
  dir_ctr_e         rd_ctr, up_ctr, new_ctr;
  logic             upd_fire, upd_hit, wr_en, wr_tgt_en;
  logic [OFS_W-1:0] unused_upd_low;

  assign f_idx = fetch_pc[IDX_W+OFS_W-1:OFS_W];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+OFS_W];
  assign u_idx = upd_pc[IDX_W+OFS_W-1:OFS_W];
  assign u_tag = upd_pc[PC_W-1:IDX_W+OFS_W];
  assign unused_upd_low = upd_pc[OFS_W-1:0];

  assign upd_ready = !flush;
  assign upd_fire  = upd_valid && upd_ready;
  assign upd_hit   = up_valid && (up_tag == u_tag);
  assign wr_en     = upd_fire && (upd_hit || upd_taken);
  assign wr_tgt_en = upd_taken;

  btb_entry_store #(.TAG_W(TAG_W), .TGT_W(PC_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .wr_en     (wr_en),
    .wr_idx    (u_idx),
    .wr_tag    (u_tag),
    .wr_tgt_en (wr_tgt_en),
    .wr_target (upd_target),
    .wr_ctr    (new_ctr),
    .rd_idx    (f_idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_target (rd_target),
    .rd_ctr    (rd_ctr),
    .up_idx    (u_idx),
    .up_valid  (up_valid),
    .up_tag    (up_tag),
    .up_ctr    (up_ctr)
  );

  btb_dir_train u_train (
    .hit     (upd_hit),
    .taken   (upd_taken),
    .cur_ctr (up_ctr),
    .new_ctr (new_ctr)
  );

  btb_fetch_select #(.PC_W(PC_W), .TAG_W(TAG_W)) u_sel (
    .fetch_pc   (fetch_pc),
    .pc_tag     (f_tag),
    .ent_valid  (rd_valid),
    .ent_tag    (rd_tag),
    .ent_target (rd_target),
    .ent_ctr    (rd_ctr),
    .hit        (pred_hit),
    .taken      (pred_taken),
    .next_pc    (next_pc)
  );
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] next_pc,
  input logic            upd_valid,
  input logic            upd_ready,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);
  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  p_miss_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (next_pc == fetch_pc + PC_W'(4)));

  p_flush_blocks_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !upd_ready);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_hit);

  p_notaken_no_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && !upd_taken && !pred_hit && fetch_pc == upd_pc)
    |=> (!pred_hit || fetch_pc != $past(fetch_pc)));

  p_alloc_weak_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready && upd_taken && !pred_hit && fetch_pc == upd_pc)
    |=> ((fetch_pc != $past(fetch_pc)) ||
         (pred_hit && pred_taken && next_pc == $past(upd_target))));
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .fetch_pc   (fetch_pc),
  .pred_hit   (pred_hit),
  .pred_taken (pred_taken),
  .next_pc    (next_pc),
  .upd_valid  (upd_valid),
  .upd_ready  (upd_ready),
  .upd_pc     (upd_pc),
  .upd_taken  (upd_taken),
  .upd_target (upd_target)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int PC_W = 32;

  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] utgt;
    logic [31:0] lpc;
    logic        eh;
    logic        et;
    logic [31:0] enx;
    logic [7:0]  req;
  } vec_t;

  localparam logic [31:0] PA = 32'h0000_1010; // index 4
  localparam logic [31:0] PB = 32'h0000_5010; // index 4, other tag
  localparam logic [31:0] PC = 32'h0000_1020; // index 8
  localparam int NV = 25;

  // Each row: update offered this cycle, lookup checked in the same cycle.
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b0, 1'b0, 32'h1014, 8'd2},  // R2
    '{1'b1, PA,    1'b0, 32'h2000, PA, 1'b0, 1'b0, 32'h1014, 8'd4},  // R4
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b0, 1'b0, 32'h1014, 8'd4},  // R4
    '{1'b1, PA,    1'b1, 32'h2000, PA, 1'b0, 1'b0, 32'h1014, 8'd10}, // R10
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h2000, 8'd3},  // R3
    '{1'b1, PA,    1'b1, 32'h2000, PA, 1'b1, 1'b1, 32'h2000, 8'd3},  // R3
    '{1'b1, PA,    1'b0, 32'h2000, PA, 1'b1, 1'b1, 32'h2000, 8'd5},  // R5
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h2000, 8'd5},  // R5
    '{1'b1, PA,    1'b0, 32'h2000, PA, 1'b1, 1'b1, 32'h2000, 8'd5},  // R5
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b1, 1'b0, 32'h1014, 8'd5},  // R5
    '{1'b1, PA,    1'b0, 32'h2000, PA, 1'b1, 1'b0, 32'h1014, 8'd6},  // R6
    '{1'b1, PA,    1'b0, 32'h2000, PA, 1'b1, 1'b0, 32'h1014, 8'd6},  // R6
    '{1'b1, PA,    1'b1, 32'h2000, PA, 1'b1, 1'b0, 32'h1014, 8'd6},  // R6
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b1, 1'b0, 32'h1014, 8'd6},  // R6
    '{1'b1, PA,    1'b1, 32'h3000, PA, 1'b1, 1'b0, 32'h1014, 8'd7},  // R7
    '{1'b1, PA,    1'b1, 32'h3000, PA, 1'b1, 1'b1, 32'h3000, 8'd7},  // R7
    '{1'b1, PA,    1'b0, 32'h4444, PA, 1'b1, 1'b1, 32'h3000, 8'd7},  // R7
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h3000, 8'd7},  // R7
    '{1'b0, 32'h0, 1'b0, 32'h0,    PB, 1'b0, 1'b0, 32'h5014, 8'd8},  // R8
    '{1'b1, PB,    1'b1, 32'h6000, PA, 1'b1, 1'b1, 32'h3000, 8'd8},  // R8
    '{1'b0, 32'h0, 1'b0, 32'h0,    PA, 1'b0, 1'b0, 32'h1014, 8'd8},  // R8
    '{1'b0, 32'h0, 1'b0, 32'h0,    PB, 1'b1, 1'b1, 32'h6000, 8'd8},  // R8
    '{1'b1, PC,    1'b1, 32'h7000, PC, 1'b0, 1'b0, 32'h1024, 8'd11}, // R11
    '{1'b1, PB,    1'b0, 32'h0,    PC, 1'b1, 1'b1, 32'h7000, 8'd11}, // R11
    '{1'b0, 32'h0, 1'b0, 32'h0,    PB, 1'b1, 1'b0, 32'h5014, 8'd8}   // R8
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            flush = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_hit, pred_taken, upd_ready;
  logic [PC_W-1:0] next_pc;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] pc, input logic eh,
                      input logic et, input logic [31:0] enx);
    fetch_pc = pc;
    #1;
    chk({tag, " hit"}, 32'(pred_hit), 32'(eh));
    chk({tag, " taken"}, 32'(pred_taken), 32'(et));
    chk({tag, " next_pc"}, next_pc, enx);
  endtask

  task automatic idle_update();
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty after reset
    look("R1 reset lookup", PA, 1'b0, 1'b0, 32'h1014);
    chk("R1 ready after reset", 32'(upd_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_valid = VEC[i].uv; upd_pc = VEC[i].upc;
      upd_taken = VEC[i].ut; upd_target = VEC[i].utgt;
      look($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].lpc,
           VEC[i].eh, VEC[i].et, VEC[i].enx);
      chk($sformatf("R%0d vector %0d ready", VEC[i].req, i), 32'(upd_ready), 32'd1);
    end

    // R9: flush with an update offered in the same cycle
    @(negedge clk);
    flush = 1'b1; upd_valid = 1'b1; upd_pc = PC; upd_taken = 1'b1; upd_target = 32'h8000;
    #1 chk("R9 ready low in flush", 32'(upd_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0; idle_update();
    look("R9 C after flush", PC, 1'b0, 1'b0, 32'h1024);
    look("R9 B after flush", PB, 1'b0, 1'b0, 32'h5014);
    chk("R9 ready restored", 32'(upd_ready), 32'd1);

    // R3: allocation works again after flush
    upd_valid = 1'b1; upd_pc = PC; upd_taken = 1'b1; upd_target = 32'h9000;
    @(negedge clk);
    idle_update();
    look("R3 realloc after flush", PC, 1'b1, 1'b1, 32'h9000);

    // R1: reset in mid-run empties the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look("R1 reset mid-run", PC, 1'b0, 1'b0, 32'h1024);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule